// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is the coherence controller of one private cache in a bus-based multiprocessor that keeps copies consistent by broadcasting written words rather than by invalidating copies. It holds a small direct-mapped array with one data word per line. Every line that is present is in one of four states: exclusive clean (E), shared clean (Sc), shared owned-dirty (Sm) or exclusive dirty (M). A separate valid bit per line is cleared at reset, so that the first access to each line misses. There is no invalid coherence state.

On the processor side the controller accepts read, write and replace requests. It answers each request with a one-cycle done pulse. Toward the bus it issues three kinds of transaction: a block read, a single-word update, and a write-back. It samples the wired-OR shared line in the cycle that follows its own grant. On the snoop side it watches the transactions of other caches. It drives its own contribution to the shared line, overwrites its copy when it sees an update, and supplies the word itself when it owns a block that another cache reads. A write to a line that may be shared is applied to the local copy only when its update is granted, so every cache sees the writes to that location in bus order.

Top module: `dragon_cache_ctrl`

## Requirements
- R1: After reset all lines are absent, and `cpu_done`, `bus_req`, `snp_shared` and `snp_supply` are low. The first read of any address issues a bus read.
- R2: A read that hits raises `cpu_done` in the cycle after the request is accepted, with the stored word on `cpu_rdata`, and issues no bus request.
- R3: A read miss issues a bus read (`bus_cmd` = 1) for the request address. The bus word becomes the line's data and is returned on `cpu_rdata`. The line fills as Sc if `bus_shared_in` was high in the response cycle, and as E otherwise.
- R4: A write that hits a line in E or M issues no bus request and leaves the line in M holding the new word.
- R5: A write that hits a line in Sc or Sm issues exactly one update (`bus_cmd` = 2) carrying the address and the new word. The line ends in Sm if `bus_shared_in` was high in the response cycle, and in M otherwise.
- R6: A write miss first issues a bus read. If the shared line was high, an update with the new word follows. Otherwise the line loads as M with the new word and no update is sent.
- R7: A write-back (`bus_cmd` = 3) carrying the old address and word is sent only for lines in M or Sm: on a miss whose victim is one of these, before the read, and on a replace of such a line. A replace of an E or Sc line is silent. After a replace the line is absent.
- R8: A snooped bus read that hits a present line raises `snp_shared` one cycle later. If the line is in M or Sm it also raises `snp_supply` with the word on `snp_data` and ends in Sm. E becomes Sc.
- R9: A snooped update that hits raises `snp_shared` one cycle later without `snp_supply`, overwrites the stored word with `snp_wdata`, and leaves the line in Sc.
- R10: Snooped transactions that miss, and snooped write-backs, raise neither `snp_shared` nor `snp_supply` and change nothing.
- R11: `bus_req`, `bus_cmd` and `bus_addr` hold steady until `bus_gnt`. The local word of a pending update is not written before its grant, so a snooped read during the wait is supplied the old word.
- R12: A processor request that arrives in the same cycle as a snooped transaction is taken after the snoop has been applied. A write to an E line that another cache reads in that cycle therefore issues an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_op | input | 2 | 0 read, 1 write, 2 replace |
| cpu_addr | input | ADDR_W | Word address (low bits select the line) |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` |
| bus_req | output | 1 | Request for the bus |
| bus_cmd | output | 2 | 0 idle, 1 read, 2 update, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Word for update or write-back |
| bus_gnt | input | 1 | Grant; the transaction occupies this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled in the cycle after grant |
| bus_rdata | input | DATA_W | Fill word, sampled in the cycle after a read grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wdata | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache's drive of the shared line, one cycle after the snoop |
| snp_supply | output | 1 | This cache supplies the block |
| snp_data | output | DATA_W | Supplied word |

## Verification
A wrong line state shows at the ports at the next transaction that touches the line. A clean state held where a dirty one is expected drops `snp_supply` on the next snooped read, one cycle after it, or leaves out a write-back on replace. A shared state held where an exclusive one is expected produces an update where the processor write should have been silent. A local word written too early shows as a wrong `snp_data` when another cache reads the line before the update is granted. A wrong word after a snooped update shows on the next read hit, in the cycle after the request.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

  typedef enum logic [1:0] {
    LS_E  = 2'd0,
    LS_SC = 2'd1,
    LS_SM = 2'd2,
    LS_M  = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_IDLE  = 2'd0,
    BC_READ  = 2'd1,
    BC_UPD   = 2'd2,
    BC_WB    = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_REPLACE = 2'd2,
    OP_RSVD    = 2'd3
  } cpu_op_t;

  typedef enum logic [2:0] {
    F_IDLE,
    F_WB,
    F_RD,
    F_RD_RSP,
    F_UPD,
    F_UPD_RSP
  } fsm_t;

  function automatic logic is_owner(line_st_t s);
    return (s == LS_SM) || (s == LS_M);
  endfunction

endpackage

// File: rtl/dragon_line_store.sv
module dragon_line_store
  import dragon_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_t          a_state,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic [TAG_W-1:0]  b_tag,
  output line_st_t          b_state,
  output logic [DATA_W-1:0] b_data,
  input  logic              f_meta_we,
  input  logic              f_data_we,
  input  logic [IDX_W-1:0]  f_idx,
  input  logic              f_valid,
  input  logic [TAG_W-1:0]  f_tag,
  input  line_st_t          f_state,
  input  logic [DATA_W-1:0] f_data,
  input  logic              s_we,
  input  logic              s_data_we,
  input  logic [IDX_W-1:0]  s_idx,
  input  line_st_t          s_state,
  input  logic [DATA_W-1:0] s_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  line_st_t          st_mem   [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  // Valid bits are the only reset state; arrays are plain RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (f_meta_we) begin
      valid_q[f_idx] <= f_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (f_meta_we) begin
      tag_mem[f_idx] <= f_tag;
      st_mem[f_idx]  <= f_state;
    end else if (s_we) begin
      st_mem[s_idx]  <= s_state;
    end
  end

  always_ff @(posedge clk) begin
    if (f_data_we) begin
      data_mem[f_idx] <= f_data;
    end else if (s_data_we) begin
      data_mem[s_idx] <= s_data;
    end
  end

  assign a_valid = valid_q[a_idx];
  assign a_tag   = tag_mem[a_idx];
  assign a_state = st_mem[a_idx];
  assign a_data  = data_mem[a_idx];
  assign b_valid = valid_q[b_idx];
  assign b_tag   = tag_mem[b_idx];
  assign b_state = st_mem[b_idx];
  assign b_data  = data_mem[b_idx];

endmodule

// File: rtl/dragon_snoop.sv
module dragon_snoop
  import dragon_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [ADDR_W-1:0]       snp_addr,
  input  logic [DATA_W-1:0]       snp_wdata,
  output logic [IDX_W-1:0]        b_idx,
  input  logic                    b_valid,
  input  logic [ADDR_W-IDX_W-1:0] b_tag,
  input  line_st_t                b_state,
  input  logic [DATA_W-1:0]       b_data,
  output logic                    s_we,
  output logic                    s_data_we,
  output line_st_t                s_state,
  output logic [DATA_W-1:0]       s_data,
  output logic                    snp_shared,
  output logic                    snp_supply,
  output logic [DATA_W-1:0]       snp_data
);
  bus_cmd_t cmd;
  logic     tag_hit, is_rd, is_upd, owner;

  assign cmd     = bus_cmd_t'(snp_cmd);
  assign b_idx   = snp_addr[IDX_W-1:0];
  assign is_rd   = snp_valid && (cmd == BC_READ);
  assign is_upd  = snp_valid && (cmd == BC_UPD);
  assign tag_hit = b_valid && (b_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign owner   = is_owner(b_state);

  always_comb begin
    s_we      = tag_hit && (is_rd || is_upd);
    s_data_we = tag_hit && is_upd;
    s_data    = snp_wdata;
    if (is_upd)     s_state = LS_SC;
    else if (owner) s_state = LS_SM;
    else            s_state = LS_SC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_shared <= 1'b0;
      snp_supply <= 1'b0;
      snp_data   <= '0;
    end else begin
      snp_shared <= tag_hit && (is_rd || is_upd);
      snp_supply <= tag_hit && is_rd && owner;
      snp_data   <= (tag_hit && is_rd && owner) ? b_data : '0;
    end
  end

endmodule

// File: rtl/dragon_cpu_fsm.sv
module dragon_cpu_fsm
  import dragon_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic [1:0]              cpu_op,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_done,
  output logic [DATA_W-1:0]       cpu_rdata,
  input  logic                    snp_valid,
  input  logic                    bus_gnt,
  input  logic                    bus_shared_in,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_req,
  output logic [1:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  output logic [IDX_W-1:0]        a_idx,
  input  logic                    a_valid,
  input  logic [ADDR_W-IDX_W-1:0] a_tag,
  input  line_st_t                a_state,
  input  logic [DATA_W-1:0]       a_data,
  output logic                    f_meta_we,
  output logic                    f_data_we,
  output logic [IDX_W-1:0]        f_idx,
  output logic                    f_valid,
  output logic [ADDR_W-IDX_W-1:0] f_tag,
  output line_st_t                f_state,
  output logic [DATA_W-1:0]       f_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_t              st;
  cpu_op_t           op_q;
  cpu_op_t           op_in;
  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic [DATA_W-1:0] wdata_q;
  logic [TAG_W-1:0]  cur_tag;
  logic              accept, hit, dirty, excl;

  assign op_in    = cpu_op_t'(cpu_op);
  assign accept   = (st == F_IDLE) && cpu_req && !cpu_done && !snp_valid;
  assign cur_addr = (st == F_IDLE) ? cpu_addr : addr_q;
  assign a_idx    = cur_addr[IDX_W-1:0];
  assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
  assign hit      = a_valid && (a_tag == cur_tag);
  assign dirty    = a_valid && is_owner(a_state);
  assign excl     = (a_state == LS_E) || (a_state == LS_M);

  // Array write requests.
  always_comb begin
    f_meta_we = 1'b0;
    f_data_we = 1'b0;
    f_idx     = a_idx;
    f_valid   = 1'b1;
    f_tag     = cur_tag;
    f_state   = a_state;
    f_data    = wdata_q;
    case (st)
      F_IDLE: begin
        if (accept && op_in == OP_WRITE && hit && excl) begin
          f_meta_we = 1'b1;
          f_data_we = 1'b1;
          f_state   = LS_M;
          f_data    = cpu_wdata;
        end else if (accept && op_in == OP_REPLACE && hit && !dirty) begin
          f_meta_we = 1'b1;
          f_valid   = 1'b0;
        end
      end
      F_WB: begin
        if (bus_gnt && op_q == OP_REPLACE) begin
          f_meta_we = 1'b1;
          f_valid   = 1'b0;
        end
      end
      F_RD_RSP: begin
        f_meta_we = 1'b1;
        f_data_we = 1'b1;
        if (op_q == OP_READ) f_state = bus_shared_in ? LS_SC : LS_E;
        else                 f_state = bus_shared_in ? LS_SM : LS_M;
        f_data = (op_q == OP_READ || bus_shared_in) ? bus_rdata : wdata_q;
      end
      F_UPD: begin
        f_data_we = bus_gnt;
      end
      F_UPD_RSP: begin
        f_meta_we = 1'b1;
        f_state   = bus_shared_in ? LS_SM : LS_M;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= F_IDLE;
      op_q      <= OP_READ;
      addr_q    <= '0;
      wdata_q   <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      bus_req   <= 1'b0;
      bus_cmd   <= BC_IDLE;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (st)
        F_IDLE: begin
          if (accept) begin
            op_q    <= op_in;
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
            if (op_in == OP_REPLACE || op_in == OP_RSVD) begin
              if (op_in == OP_REPLACE && hit && dirty) begin
                bus_req   <= 1'b1;
                bus_cmd   <= BC_WB;
                bus_addr  <= {a_tag, a_idx};
                bus_wdata <= a_data;
                st        <= F_WB;
              end else begin
                cpu_done <= 1'b1;
              end
            end else if (hit) begin
              if (op_in == OP_READ || excl) begin
                cpu_done  <= 1'b1;
                cpu_rdata <= (op_in == OP_READ) ? a_data : cpu_rdata;
              end else begin
                bus_req   <= 1'b1;
                bus_cmd   <= BC_UPD;
                bus_addr  <= cpu_addr;
                bus_wdata <= cpu_wdata;
                st        <= F_UPD;
              end
            end else if (dirty) begin
              bus_req   <= 1'b1;
              bus_cmd   <= BC_WB;
              bus_addr  <= {a_tag, a_idx};
              bus_wdata <= a_data;
              st        <= F_WB;
            end else begin
              bus_req  <= 1'b1;
              bus_cmd  <= BC_READ;
              bus_addr <= cpu_addr;
              st       <= F_RD;
            end
          end
        end
        F_WB: begin
          if (bus_gnt) begin
            if (op_q == OP_REPLACE) begin
              bus_req  <= 1'b0;
              bus_cmd  <= BC_IDLE;
              cpu_done <= 1'b1;
              st       <= F_IDLE;
            end else begin
              bus_cmd  <= BC_READ;
              bus_addr <= addr_q;
              st       <= F_RD;
            end
          end
        end
        F_RD: begin
          if (bus_gnt) begin
            bus_req <= 1'b0;
            bus_cmd <= BC_IDLE;
            st      <= F_RD_RSP;
          end
        end
        F_RD_RSP: begin
          if (op_q == OP_WRITE && bus_shared_in) begin
            bus_req   <= 1'b1;
            bus_cmd   <= BC_UPD;
            bus_addr  <= addr_q;
            bus_wdata <= wdata_q;
            st        <= F_UPD;
          end else begin
            cpu_done  <= 1'b1;
            cpu_rdata <= (op_q == OP_READ) ? bus_rdata : cpu_rdata;
            st        <= F_IDLE;
          end
        end
        F_UPD: begin
          if (bus_gnt) begin
            bus_req <= 1'b0;
            bus_cmd <= BC_IDLE;
            st      <= F_UPD_RSP;
          end
        end
        F_UPD_RSP: begin
          cpu_done <= 1'b1;
          st       <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dragon_cache_ctrl.sv
module dragon_cache_ctrl
  import dragon_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx, f_idx, s_idx;
  logic              a_valid, b_valid;
  logic [TAG_W-1:0]  a_tag, b_tag, f_tag;
  line_st_t          a_state, b_state, f_state, s_state;
  logic [DATA_W-1:0] a_data, b_data, f_data, s_data;
  logic              f_meta_we, f_data_we, f_valid, s_we, s_data_we;

  assign s_idx = b_idx;

  dragon_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rst(rst),
    .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_state(a_state), .a_data(a_data),
    .b_idx(b_idx), .b_valid(b_valid), .b_tag(b_tag), .b_state(b_state), .b_data(b_data),
    .f_meta_we(f_meta_we), .f_data_we(f_data_we), .f_idx(f_idx), .f_valid(f_valid),
    .f_tag(f_tag), .f_state(f_state), .f_data(f_data),
    .s_we(s_we), .s_data_we(s_data_we), .s_idx(s_idx), .s_state(s_state), .s_data(s_data)
  );

  dragon_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_wdata(snp_wdata),
    .b_idx(b_idx), .b_valid(b_valid), .b_tag(b_tag), .b_state(b_state), .b_data(b_data),
    .s_we(s_we), .s_data_we(s_data_we), .s_state(s_state), .s_data(s_data),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  dragon_cpu_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_fsm (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .snp_valid(snp_valid), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata),
    .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_state(a_state), .a_data(a_data),
    .f_meta_we(f_meta_we), .f_data_we(f_data_we), .f_idx(f_idx), .f_valid(f_valid),
    .f_tag(f_tag), .f_state(f_state), .f_data(f_data)
  );

endmodule

// File: rtl/dragon_cache_chk.sv
module dragon_cache_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_valid,
  input logic              snp_shared,
  input logic              snp_supply,
  input logic              f_meta_we,
  input logic              f_data_we,
  input logic              s_we
);

  AST_ONE_ARRAY_WRITER: assert property (@(posedge clk) disable iff (rst)
    !((f_meta_we || f_data_we) && s_we)); // R12

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr))); // R11

  AST_SUPPLY_IS_SHARED: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> snp_shared); // R8

  AST_SHARED_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (rst)
    snp_shared |-> $past(snp_valid)); // R10

endmodule

bind dragon_cache_ctrl dragon_cache_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
  .bus_addr(bus_addr), .snp_valid(snp_valid), .snp_shared(snp_shared),
  .snp_supply(snp_supply), .f_meta_we(f_meta_we), .f_data_we(f_data_we), .s_we(s_we)
);

// File: tb/test_dragon_cache_ctrl.sv
module test_dragon_cache_ctrl;
  localparam int ADDR_W = 8, DATA_W = 16, LINES = 8;
  localparam int ST_E = 0, ST_SC = 1, ST_SM = 2, ST_M = 3;
  localparam int C_RD = 1, C_UPD = 2, C_WB = 3;
  localparam int O_RD = 0, O_WR = 1, O_RPL = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 0; logic [1:0] cpu_op = 0;
  logic [ADDR_W-1:0] cpu_addr = 0; logic [DATA_W-1:0] cpu_wdata = 0;
  logic cpu_done; logic [DATA_W-1:0] cpu_rdata;
  logic bus_req; logic [1:0] bus_cmd; logic [ADDR_W-1:0] bus_addr; logic [DATA_W-1:0] bus_wdata;
  logic bus_gnt = 0, bus_shared_in = 0; logic [DATA_W-1:0] bus_rdata = 0;
  logic snp_valid = 0; logic [1:0] snp_cmd = 0; logic [ADDR_W-1:0] snp_addr = 0;
  logic [DATA_W-1:0] snp_wdata = 0;
  logic snp_shared, snp_supply; logic [DATA_W-1:0] snp_data;

  int vectors = 0, miscompares = 0;
  bit          mv [LINES];
  logic [4:0]  mt [LINES];
  int          ms [LINES];
  logic [15:0] md [LINES];

  always #10ns clk = ~clk;

  dragon_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) i_dragon_cache_ctrl (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_wdata(snp_wdata),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Expected snoop response; updates the model (R8, R9, R10).
  task automatic snp_model(input int cmd, input logic [7:0] a, input logic [15:0] w,
                           output logic sh, output logic sup, output logic [15:0] dat);
    int idx = int'(a[2:0]);
    bit h = mv[idx] && (mt[idx] == a[7:3]) && (cmd == C_RD || cmd == C_UPD);
    sh = h;
    sup = h && cmd == C_RD && (ms[idx] == ST_SM || ms[idx] == ST_M);
    dat = sup ? md[idx] : 16'h0;
    if (h && cmd == C_RD) ms[idx] = (ms[idx] == ST_E || ms[idx] == ST_SC) ? ST_SC : ST_SM;
    if (h && cmd == C_UPD) begin ms[idx] = ST_SC; md[idx] = w; end
  endtask

  task automatic snoop(input int cmd, input logic [7:0] a, input logic [15:0] w, input string tg);
    logic esh, esup; logic [15:0] edat;
    snp_model(cmd, a, w, esh, esup, edat);
    snp_valid = 1; snp_cmd = cmd[1:0]; snp_addr = a; snp_wdata = w;
    @(negedge clk);
    snp_valid = 0;
    chk({tg, " snp_shared"}, {31'b0, snp_shared}, {31'b0, esh});
    chk({tg, " snp_supply"}, {31'b0, snp_supply}, {31'b0, esup});
    chk({tg, " snp_data"}, {16'b0, snp_data}, {16'b0, edat});
  endtask

  task automatic bus_txn(input int cmd, input logic [7:0] a, input logic [15:0] d,
                         input bit sh, input logic [15:0] rd, input bit mid, input string tg);
    int n = 0;
    while (!bus_req && n < 50) begin @(negedge clk); n++; end
    if (!bus_req) begin
      miscompares++; vectors++;
      $display("FAIL %s: no bus request, actual 0 expected 1", tg);
      return;
    end
    repeat ($urandom % 3) @(negedge clk);
    if (mid) snoop(C_RD, a, 16'h0, {tg, " R11 snoop before grant"});
    chk({tg, " bus_cmd"}, {30'b0, bus_cmd}, cmd);
    chk({tg, " bus_addr"}, {24'b0, bus_addr}, {24'b0, a});
    if (cmd != C_RD) chk({tg, " bus_wdata"}, {16'b0, bus_wdata}, {16'b0, d});
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    if (cmd != C_WB) begin
      bus_shared_in = sh; bus_rdata = rd;
      @(negedge clk);
      bus_shared_in = 0; bus_rdata = 0;
    end
  endtask

  task automatic wait_done(input bit is_rd, input logic [15:0] exp, input string tg);
    int n = 0;
    while (!cpu_done && n < 50) begin
      if (bus_req) begin
        miscompares++; vectors++;
        $display("FAIL %s: unexpected bus request, actual 1 expected 0", tg);
        bus_gnt = 1; @(negedge clk); bus_gnt = 0;
      end else @(negedge clk);
      n++;
    end
    chk({tg, " cpu_done"}, {31'b0, cpu_done}, 1);
    if (is_rd) chk({tg, " cpu_rdata"}, {16'b0, cpu_rdata}, {16'b0, exp});
    cpu_req = 0;
    @(negedge clk);
  endtask

  task automatic do_op(input int op, input logic [7:0] a, input logic [15:0] w,
                       input bit conc, input bit mid, input string tg);
    int idx = int'(a[2:0]);
    bit hit, dirty, sh1, sh2;
    logic [15:0] rd = 16'($urandom);
    sh1 = bit'($urandom % 2); sh2 = bit'($urandom % 2);
    cpu_req = 1; cpu_op = op[1:0]; cpu_addr = a; cpu_wdata = w;
    if (conc) snoop(C_RD, a, 16'h0, {tg, " R12 same-cycle snoop"});
    hit = mv[idx] && mt[idx] == a[7:3];
    dirty = mv[idx] && (ms[idx] == ST_SM || ms[idx] == ST_M);
    if (op == O_RD) begin
      if (hit) wait_done(1, md[idx], {tg, " R2 read hit"});
      else begin
        if (dirty) bus_txn(C_WB, {mt[idx], a[2:0]}, md[idx], 0, 0, 0, {tg, " R7 victim wb"});
        bus_txn(C_RD, a, 0, sh1, rd, 0, {tg, " R3 read miss"});
        mv[idx] = 1; mt[idx] = a[7:3]; ms[idx] = sh1 ? ST_SC : ST_E; md[idx] = rd;
        wait_done(1, rd, {tg, " R3 fill"});
      end
    end else if (op == O_WR) begin
      if (hit && (ms[idx] == ST_E || ms[idx] == ST_M)) begin
        ms[idx] = ST_M; md[idx] = w;
        wait_done(0, 0, {tg, " R4 silent write"});
      end else if (hit) begin
        bus_txn(C_UPD, a, w, sh1, 0, mid, {tg, " R5 update"});
        ms[idx] = sh1 ? ST_SM : ST_M; md[idx] = w;
        wait_done(0, 0, {tg, " R5 done"});
      end else begin
        if (dirty) bus_txn(C_WB, {mt[idx], a[2:0]}, md[idx], 0, 0, 0, {tg, " R7 victim wb"});
        bus_txn(C_RD, a, 0, sh1, rd, 0, {tg, " R6 write miss read"});
        mv[idx] = 1; mt[idx] = a[7:3]; md[idx] = rd;
        if (sh1) begin
          ms[idx] = ST_SM;
          bus_txn(C_UPD, a, w, sh2, 0, 0, {tg, " R6 follow-up update"});
          ms[idx] = sh2 ? ST_SM : ST_M;
        end else ms[idx] = ST_M;
        md[idx] = w;
        wait_done(0, 0, {tg, " R6 done"});
      end
    end else begin
      if (hit && dirty) bus_txn(C_WB, a, md[idx], 0, 0, 0, {tg, " R7 replace wb"});
      if (hit) mv[idx] = 0;
      wait_done(0, 0, {tg, " R7 replace"});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; mt[i] = 0; ms[i] = 0; md[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset bus_req", {31'b0, bus_req}, 0);
    chk("R1 reset cpu_done", {31'b0, cpu_done}, 0);
    chk("R1 reset snp_shared", {31'b0, snp_shared}, 0);
    chk("R1 reset snp_supply", {31'b0, snp_supply}, 0);

    // Directed corner cases
    do_op(O_RD, 8'h11, 0, 0, 0, "R1 first read");
    do_op(O_RD, 8'h11, 0, 0, 0, "R2");
    snoop(C_RD, 8'h11, 0, "R8 snoop read");
    do_op(O_WR, 8'h11, 16'hA5A5, 0, 0, "R5 write Sc");
    snoop(C_RD, 8'h11, 0, "R8 snoop read owner");
    do_op(O_WR, 8'h11, 16'h1234, 0, 1, "R11 pending update");
    snoop(C_UPD, 8'h11, 16'hBEEF, "R9 snoop update");
    do_op(O_RD, 8'h11, 0, 0, 0, "R9 read after update");
    do_op(O_WR, 8'h22, 16'h2222, 0, 0, "R6 write miss");
    do_op(O_WR, 8'h22, 16'h3333, 0, 0, "R4 write");
    do_op(O_WR, 8'h2A, 16'h4444, 0, 0, "R7 dirty victim");
    do_op(O_RPL, 8'h2A, 0, 0, 0, "R7 replace");
    do_op(O_RD, 8'h2A, 0, 0, 0, "R7 absent after replace");
    do_op(O_RD, 8'h33, 0, 0, 0, "R3");
    do_op(O_RPL, 8'h33, 0, 0, 0, "R7 clean replace");
    do_op(O_RD, 8'h33, 0, 0, 0, "R7 refill");
    snoop(C_RD, 8'h44, 0, "R10 snoop miss");
    snoop(C_WB, 8'h11, 16'h7777, "R10 snoop write-back");
    do_op(O_RD, 8'h11, 0, 0, 0, "R10 word unchanged");
    mv[5] = mv[5];
    do_op(O_RD, 8'h55, 0, 0, 0, "R12 setup");
    if (ms[5] == ST_E) do_op(O_WR, 8'h55, 16'h5555, 1, 0, "R12");
    do_op(O_RD, 8'h66, 0, 0, 0, "R4 setup");
    do_op(O_WR, 8'h66, 16'h6666, 0, 0, "R4");

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 10;
      logic [7:0] a = {5'($urandom % 3), 3'($urandom % LINES)};
      int idx = int'(a[2:0]);
      if (r < 7) begin
        int op = ($urandom % 5 == 0) ? O_RPL : int'($urandom % 2);
        do_op(op, a, 16'($urandom), bit'($urandom % 8 == 0), bit'($urandom % 4 == 0), "random op");
      end else if (r < 9) begin
        bit ok_upd = !(mv[idx] && mt[idx] == a[7:3]) || ms[idx] == ST_SC || ms[idx] == ST_SM;
        snoop((r == 8 && ok_upd) ? C_UPD : C_RD, a, 16'($urandom), "random snoop R8 R9");
      end else begin
        snoop(C_WB, a, 16'($urandom), "random snoop R10");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule